// File: doc/BRIEF.md
# Stream-to-Segmented Packet Bus Bridge

This block takes a 512-bit AXI4-Stream transmit stream and presents it as a packet bus made of four 128-bit segments. Each segment has its own enable, start, end, error and empty-byte-count signals. AXI byte 0 sits in bits [7:0] of the stream word. On the segmented side, the first byte a segment carries sits in that segment's top byte. The bridge therefore places the word's bytes into the segments in sequence and reverses the byte order inside each segment.

The datapath is purely combinational. The only register is a small frame tracker that remembers whether the next accepted beat opens a new frame. Every frame starts in segment 0 of a fresh cycle, and two frames never share a cycle. Backpressure passes straight through: the upstream ready is the downstream ready. Malformed byte-enable patterns are reported on an error output but are still forwarded.

Top module: `segbus_bridge`

## Requirements
- R1: Output byte j of segment i (bits [i*128+127-8j -: 8] of `seg_data`) equals stream byte 16i+j (bits [(16i+j)*8 +: 8] of `s_tdata`).
- R2: `seg_ena[i]` is high exactly when `s_tvalid` is high and at least one of `s_tkeep[16i+15:16i]` is set.
- R3: `seg_sop[0]` is high on the first beat of a frame: the first valid beat after reset or after an accepted beat with `s_tlast`, and only when segment 0 is enabled. It is low on all later beats of the frame. `seg_sop[3:1]` are always low.
- R4: On a valid beat with `s_tlast`, `seg_eop` is high only for the highest enabled segment. On any other beat, `seg_eop` is all zero.
- R5: `seg_mty[4i+3:4i]` equals 16 minus the number of set keep bits of segment i when that segment has `seg_eop[i]` high, and is 0 otherwise.
- R6: `s_tready` equals `seg_rdy`. A beat counts as accepted only when `s_tvalid` and `s_tready` are both high. While no beat is accepted, the frame position does not change, so a stalled first beat keeps `seg_sop[0]` high.
- R7: `keep_err` is high on a valid beat whose `s_tkeep` is zero, is not contiguous from bit 0, or is not all ones without `s_tlast`. In those cases `seg_err` equals `seg_ena`. Otherwise both are low.
- R8: After synchronous active-low reset, even one asserted in the middle of a frame, the next valid beat is treated as a frame start.
- R9: While `s_tvalid` is low, `seg_ena`, `seg_sop`, `seg_eop`, `seg_err` and `keep_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | 512 | Stream data, byte 0 in [7:0] |
| s_tkeep | input | 64 | Stream byte enables |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Last beat of frame |
| s_tready | output | 1 | Stream ready (copy of seg_rdy) |
| seg_data | output | 512 | Four 128-bit segments, segment i at [128i+127:128i], first byte on top |
| seg_ena | output | 4 | Per-segment enable |
| seg_sop | output | 4 | Per-segment start of frame |
| seg_eop | output | 4 | Per-segment end of frame |
| seg_err | output | 4 | Per-segment error flag |
| seg_mty | output | 16 | Per-segment empty-byte count, 4 bits each |
| seg_rdy | input | 1 | Downstream ready |
| keep_err | output | 1 | Byte-enable pattern violation |

## Verification
On every cycle, the assertions check that at most one end marker is raised and only on a last beat, that enables form a prefix on well-formed beats, that an idle bus raises no flags, and how the start marker behaves across accepted, last and stalled beats. The byte reversal, the exact empty counts for several frame lengths, the error cases and recovery from a mid-frame reset can only be shown by the bench's vectors and directed scenarios.

// File: rtl/segbus_pkg.sv
// Package: shared constants and frame-position type for the segmented bus bridge.
// Assumes byte-granular data paths throughout.
package segbus_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        FRM_AT_START = 1'b0,
        FRM_INSIDE   = 1'b1
    } frame_pos_e;
endpackage

// File: rtl/segbus_frame_tracker.sv
// Frame tracker: remembers whether the next accepted beat opens a frame.
// Assumes beat_fire is the stream handshake (valid and ready).
module segbus_frame_tracker
    import segbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat_fire,
    input  logic beat_last,
    output logic at_start
);
    frame_pos_e pos_q;

    // Advance the frame position only on an accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= FRM_AT_START;
        end else if (beat_fire) begin
            pos_q <= beat_last ? FRM_AT_START : FRM_INSIDE;
        end
    end

    // Expose the position as a simple flag.
    always_comb at_start = (pos_q == FRM_AT_START);

    // R8: the first cycle out of reset is always at a frame start.
    a_r8_start_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> at_start);
    // R6: with no accepted beat, the position holds.
    a_r6_pos_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_fire |=> $stable(at_start));
endmodule

// File: rtl/segbus_keep_check.sv
// Byte-enable checker: flags keep patterns the segmented bus cannot express.
// Assumes a legal keep is a nonzero low-aligned run of ones, full on non-last beats.
module segbus_keep_check #(
    parameter int unsigned BYTES = 64
) (
    input  logic [BYTES-1:0] keep,
    input  logic             valid,
    input  logic             last,
    output logic             bad
);
    logic [BYTES-1:0] keep_inc;
    logic             run_ok;
    logic             full;

    // Decide whether keep is a contiguous run starting at bit 0 and whether the beat is full.
    always_comb begin
        keep_inc = keep + BYTES'(1);
        run_ok   = (keep != '0) && ((keep & keep_inc) == '0);
        full     = &keep;
        bad      = valid && (!run_ok || (!last && !full));
    end
endmodule

// File: rtl/segbus_lane.sv
// Segment lane: reverses byte order for one segment and derives its flags.
// Assumes higher_any reports whether any later segment holds a valid byte.
module segbus_lane
    import segbus_pkg::*;
#(
    parameter int unsigned SEG_BYTES = 16,
    localparam int unsigned SEG_W    = SEG_BYTES * BYTE_W,
    localparam int unsigned CNT_W    = $clog2(SEG_BYTES + 1),
    localparam int unsigned MTY_W    = $clog2(SEG_BYTES)
) (
    input  logic [SEG_W-1:0]     data_le,
    input  logic [SEG_BYTES-1:0] keep,
    input  logic                 valid,
    input  logic                 last,
    input  logic                 higher_any,
    output logic [SEG_W-1:0]     data_be,
    output logic                 ena,
    output logic                 eop,
    output logic [MTY_W-1:0]     mty
);
    logic [CNT_W-1:0] nvalid;

    // Byte j of the segment goes to the j-th byte from the top.
    always_comb begin
        for (int j = 0; j < SEG_BYTES; j++) begin
            data_be[SEG_W-1-j*BYTE_W -: BYTE_W] = data_le[j*BYTE_W +: BYTE_W];
        end
    end

    // Count the set keep bits of this segment.
    always_comb begin
        nvalid = '0;
        for (int j = 0; j < SEG_BYTES; j++) begin
            nvalid = nvalid + CNT_W'(keep[j]);
        end
    end

    // Enable, end marker and empty count for this segment.
    always_comb begin
        ena = valid && (keep != '0);
        eop = ena && last && !higher_any;
        mty = eop ? MTY_W'(CNT_W'(SEG_BYTES) - nvalid) : '0;
    end
endmodule

// File: rtl/segbus_bridge.sv
// Top: AXI4-Stream word to four-segment packet bus bridge.
// Assumes one frame per cycle at most; new frames always start in segment 0.
// Backpressure is a straight wire; the datapath has no registers.
module segbus_bridge
    import segbus_pkg::*;
#(
    parameter int unsigned DATA_W = 512,
    parameter int unsigned SEG_W  = 128,
    localparam int unsigned BYTES     = DATA_W / BYTE_W,
    localparam int unsigned NSEG      = DATA_W / SEG_W,
    localparam int unsigned SEG_BYTES = SEG_W / BYTE_W,
    localparam int unsigned MTY_W     = $clog2(SEG_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       s_tdata,
    input  logic [BYTES-1:0]        s_tkeep,
    input  logic                    s_tvalid,
    input  logic                    s_tlast,
    output logic                    s_tready,
    output logic [DATA_W-1:0]       seg_data,
    output logic [NSEG-1:0]         seg_ena,
    output logic [NSEG-1:0]         seg_sop,
    output logic [NSEG-1:0]         seg_eop,
    output logic [NSEG-1:0]         seg_err,
    output logic [NSEG*MTY_W-1:0]   seg_mty,
    input  logic                    seg_rdy,
    output logic                    keep_err
);
    logic at_start;
    logic beat_fire;

    // Handshake: ready is the downstream ready, unchanged.
    always_comb begin
        s_tready  = seg_rdy;
        beat_fire = s_tvalid && seg_rdy;
    end

    segbus_frame_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_fire (beat_fire),
        .beat_last (s_tlast),
        .at_start  (at_start)
    );

    segbus_keep_check #(.BYTES(BYTES)) u_keep (
        .keep  (s_tkeep),
        .valid (s_tvalid),
        .last  (s_tlast),
        .bad   (keep_err)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NSEG; gi++) begin : g_lane
            logic higher_any;
            if (gi == NSEG - 1) begin : g_top
                assign higher_any = 1'b0;
            end else begin : g_mid
                assign higher_any = |s_tkeep[BYTES-1:(gi+1)*SEG_BYTES];
            end

            segbus_lane #(.SEG_BYTES(SEG_BYTES)) u_lane (
                .data_le    (s_tdata[gi*SEG_W +: SEG_W]),
                .keep       (s_tkeep[gi*SEG_BYTES +: SEG_BYTES]),
                .valid      (s_tvalid),
                .last       (s_tlast),
                .higher_any (higher_any),
                .data_be    (seg_data[gi*SEG_W +: SEG_W]),
                .ena        (seg_ena[gi]),
                .eop        (seg_eop[gi]),
                .mty        (seg_mty[gi*MTY_W +: MTY_W])
            );

            // Start only in segment 0; error rides on enabled segments.
            if (gi == 0) begin : g_sop0
                assign seg_sop[gi] = seg_ena[gi] && at_start;
            end else begin : g_sopn
                assign seg_sop[gi] = 1'b0;
            end
            assign seg_err[gi] = seg_ena[gi] && keep_err;
        end
    endgenerate

    // R4: one end marker at most, only on a valid last beat.
    a_r4_eop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seg_eop));
    a_r4_eop_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_eop != '0) |-> (s_tvalid && s_tlast));
    // R2: on a well-formed beat enabled segments form a prefix.
    a_r2_ena_prefix: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && !keep_err) |-> (((seg_ena + 1'b1) & seg_ena) == '0));
    // R3: no start after an accepted non-last beat.
    a_r3_no_restart_midframe: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && !s_tlast) |=> !seg_sop[0]);
    // R3: the beat after an accepted last beat starts a frame.
    a_r3_start_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && s_tlast) |=> (seg_ena[0] -> seg_sop[0]));
    // R6: a stalled start beat keeps its start marker.
    a_r6_sop_held_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_sop[0] && !seg_rdy) |=> (seg_ena[0] -> seg_sop[0]));
    // R9: an idle bus raises no flags.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !s_tvalid |-> (seg_ena == '0 && seg_eop == '0 && seg_err == '0 && !keep_err));
endmodule

// File: tb/segbus_bridge_tb_top.sv
module segbus_bridge_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [511:0] s_tdata = '0;
    logic [63:0]  s_tkeep = '0;
    logic         s_tvalid = 1'b0;
    logic         s_tlast = 1'b0;
    logic         s_tready;
    logic [511:0] seg_data;
    logic [3:0]   seg_ena, seg_sop, seg_eop, seg_err;
    logic [15:0]  seg_mty;
    logic         seg_rdy = 1'b1;
    logic         keep_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit tb_mid   = 1'b0;

    always #2 clk = ~clk;

    segbus_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tkeep(s_tkeep),
        .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .seg_data(seg_data), .seg_ena(seg_ena), .seg_sop(seg_sop),
        .seg_eop(seg_eop), .seg_err(seg_err), .seg_mty(seg_mty),
        .seg_rdy(seg_rdy), .keep_err(keep_err)
    );

    // keep[64] last[1] ena[4] eop[4] mty[16] err[1]
    localparam int NV = 11;
    localparam logic [89:0] VEC [NV] = '{
        {64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'hF, 4'h0, 16'h0000, 1'b0},
        {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'hF, 4'h8, 16'h0000, 1'b0},
        {64'h0000_0000_0000_0001, 1'b1, 4'h1, 4'h1, 16'h000F, 1'b0},
        {64'h0000_0000_0000_FFFF, 1'b1, 4'h1, 4'h1, 16'h0000, 1'b0},
        {64'h0000_0000_0001_FFFF, 1'b1, 4'h3, 4'h2, 16'h00F0, 1'b0},
        {64'h0000_00FF_FFFF_FFFF, 1'b1, 4'h7, 4'h4, 16'h0800, 1'b0},
        {64'h7FFF_FFFF_FFFF_FFFF, 1'b1, 4'hF, 4'h8, 16'h1000, 1'b0},
        {64'h0000_0000_0000_00FF, 1'b0, 4'h1, 4'h0, 16'h0000, 1'b1},
        {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'hF, 4'h8, 16'h0000, 1'b0},
        {64'h0000_0000_0000_0005, 1'b1, 4'h1, 4'h1, 16'h000E, 1'b1},
        {64'h0000_0000_0000_0000, 1'b1, 4'h0, 4'h0, 16'h0000, 1'b1}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill_data(input int seed);
        for (int k = 0; k < 64; k++) s_tdata[k*8 +: 8] = 8'((k * 7 + seed * 13) & 255);
    endtask

    // R1: every output byte against the stream byte it should carry.
    task automatic check_data();
        int bad = 0;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 16; j++)
                if (seg_data[i*128 + 127 - 8*j -: 8] !== s_tdata[(16*i + j)*8 +: 8]) bad++;
        check(bad == 0, "R1 byte mapping", 64'(bad), 64'd0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // R8/R9: reset and idle state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(seg_ena == 0 && seg_sop == 0 && seg_eop == 0 && seg_err == 0 && !keep_err,
              "R9 idle flags after reset", {seg_ena, seg_sop, seg_eop, seg_err}, 0);
        check(s_tready == 1'b1, "R6 ready follows", 64'(s_tready), 64'd1);

        // Vector walk.
        for (int v = 0; v < NV; v++) begin
            logic [63:0] kp;
            logic        lst, er;
            logic [3:0]  ena, eop;
            logic [15:0] mty;
            logic        esop;
            @(negedge clk);
            kp  = VEC[v][89:26];
            lst = VEC[v][25];
            ena = VEC[v][24:21];
            eop = VEC[v][20:17];
            mty = VEC[v][16:1];
            er  = VEC[v][0];
            fill_data(v);
            s_tkeep = kp; s_tlast = lst; s_tvalid = 1'b1;
            #1;
            esop = ena[0] && !tb_mid;
            check(seg_ena == ena, $sformatf("R2 enable v%0d", v), 64'(seg_ena), 64'(ena));
            check(seg_eop == eop, $sformatf("R4 end marker v%0d", v), 64'(seg_eop), 64'(eop));
            check(seg_mty == mty, $sformatf("R5 empty count v%0d", v), 64'(seg_mty), 64'(mty));
            check(seg_sop == {3'b000, esop}, $sformatf("R3 start v%0d", v), 64'(seg_sop), 64'(esop));
            check(keep_err == er && seg_err == (er ? ena : 4'h0),
                  $sformatf("R7 error v%0d", v), {keep_err, seg_err}, {er, (er ? ena : 4'h0)});
            check_data();
            tb_mid = !lst;
        end

        // R6: stall on a frame's first beat.
        @(negedge clk);
        s_tvalid = 1'b0;
        #1;
        check(seg_ena == 0 && seg_eop == 0, "R9 idle between frames", {seg_ena, seg_eop}, 0);
        @(negedge clk);
        seg_rdy = 1'b0;
        s_tkeep = '1; s_tlast = 1'b0; s_tvalid = 1'b1;
        #1;
        check(s_tready == 1'b0, "R6 ready low in stall", 64'(s_tready), 64'd0);
        check(seg_sop[0] == 1'b1, "R6 start in stall", 64'(seg_sop), 64'd1);
        repeat (2) @(negedge clk);
        #1;
        check(seg_sop[0] == 1'b1, "R6 start held through stall", 64'(seg_sop), 64'd1);
        @(negedge clk);
        seg_rdy = 1'b1;
        #1;
        check(seg_sop[0] == 1'b1, "R6 start on accept", 64'(seg_sop), 64'd1);
        @(negedge clk);
        #1;
        check(seg_sop == 4'h0, "R3 no start mid frame", 64'(seg_sop), 64'd0);

        // R8: reset in mid frame.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(seg_sop[0] == 1'b1, "R8 start after mid-frame reset", 64'(seg_sop), 64'd1);

        done = 1'b1;
        finish_run();
    end
endmodule